// File: doc/BRIEF.md
# Tag-Renaming Reservation Stations with a Shared Result Bus

This block is the out-of-order heart of a small floating-point style datapath. Operations arrive one per cycle on an issue port, each naming an operation, two source registers and a destination register. The block places each operation in a free reservation station of the matching class: three stations feed the adder group and two feed the multiplier group. For every source, the station receives either the value from the architectural register file or the tag of the station that will produce it. The destination register is then marked as pending on the new station's tag. This removes write-after-read and write-after-write hazards without any stall.

Stations snoop a single result bus that carries a 64-bit value and the 4-bit tag of the station that produced it. A station waiting on that tag copies the value. Once both operands are present, the station runs its fixed-latency add, subtract or multiply. A finished station asks for the bus, and a fixed-priority arbiter grants one station per cycle. The granted station broadcasts its result and becomes free. The register file takes the value only where its pending tag still matches the tag on the bus. An observation port reads back any register's value and pending tag.

Top module: `rs_core`

## Requirements
- R1: After reset, architectural register i holds the value i+1 and has no pending tag (tag 0), the result bus is idle, and `iss_ready` is high for both operation classes.
- R2: The operation codes are 0 add (j+k), 1 subtract (j-k), and 2 or 3 multiply (low 64 bits of j*k). Codes 0 and 1 use adder stations and codes 2 and 3 use multiplier stations. An operation accepted at clock edge n with both sources ready is broadcast in the cycle that follows edge n+2 (adder) or edge n+3 (multiplier).
- R3: The adder stations carry tags 1, 2 and 3, and the multiplier stations carry tags 4 and 5. Issue takes the lowest-numbered free station of the needed class. Tag 0 means "value present".
- R4: `iss_ready` is low while every station of the class selected by `iss_op` is busy. An issue presented while it is low changes no register value and no pending tag.
- R5: A source whose register is pending records the producer tag. The station copies the value at the edge that ends the producer's broadcast cycle, and its result appears on the bus in the cycle after a further 2 (adder) or 3 (multiplier) edges.
- R6: An accepted issue sets the destination's pending tag to the new station's tag. A broadcast writes its value into every register whose pending tag equals the bus tag and clears that tag. A register renamed to a newer tag keeps the newer tag and its own later value.
- R7: When a source's pending tag is on the bus in the same cycle the operation is presented, the station takes the bus value directly and counts as ready at issue.
- R8: When several stations finish in the same cycle, the lowest tag is broadcast first and the others follow in later cycles, in tag order.
- R9: A station becomes free at the edge that ends its broadcast, so the same tag never appears on the bus in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2/3 multiply) |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register (j operand) |
| iss_src2 | input | 3 | Second source register (k operand) |
| iss_ready | output | 1 | A station of the class of `iss_op` is free |
| bcast_valid | output | 1 | Result bus carries a result this cycle |
| bcast_tag | output | 4 | Tag of the broadcasting station |
| bcast_data | output | 64 | Broadcast result value |
| obs_reg | input | 3 | Register selected for observation |
| obs_value | output | 64 | Value of the observed register |
| obs_tag | output | 4 | Pending tag of the observed register (0 if none) |

## Verification
The bench builds a chain of dependent operations, where a wrong capture edge or a missed tag match moves every later broadcast cycle or leaves a station waiting forever. It presents a consumer in exactly the cycle its producer broadcasts. Without the issue-time bypass, that consumer would keep a tag that is never broadcast again and the run would hang on the watchdog. It makes an adder and a multiplier finish together on the same destination, which exposes a wrong arbitration order and also an older result overwriting a newer rename. It fills all three adder stations and then presents a fourth add. A missing structural check there would corrupt a destination's pending tag.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    localparam int DATA_W   = 64;
    localparam int TAG_W    = 4;
    localparam int NUM_REGS = 8;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int N_ADD    = 3;
    localparam int N_MUL    = 2;
    localparam int N_RS     = N_ADD + N_MUL;
    localparam int ADD_LAT  = 2;
    localparam int MUL_LAT  = 3;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_t;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_MULX = 2'd3
    } op_e;

    // Operand slot: tag zero means the value field is valid.
    typedef struct packed {
        tag_t  q;
        data_t v;
    } operand_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bcast_t;

    function automatic logic uses_mul(op_e op);
        return op[1];
    endfunction

    function automatic data_t init_value(int idx);
        return data_t'(idx + 1);
    endfunction

    function automatic data_t compute(op_e op, data_t a, data_t b);
        data_t r;
        case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            default: r = a * b;
        endcase
        return r;
    endfunction

    // Operand fetch at issue, with a same-cycle capture from the bus.
    function automatic operand_t fetch(tag_t t, data_t v, bcast_t b);
        operand_t o;
        if (t == '0) begin
            o.q = '0;
            o.v = v;
        end else if (b.valid && b.tag == t) begin
            o.q = '0;
            o.v = b.data;
        end else begin
            o.q = t;
            o.v = '0;
        end
        return o;
    endfunction
endpackage

// File: rtl/rs_arbiter.sv
`timescale 1ns/1ps
module rs_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station
    import rs_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     alloc,
    input  op_e      op_in,
    input  operand_t opj_in,
    input  operand_t opk_in,
    input  bcast_t   bus,
    input  logic     grant,
    output logic     busy,
    output logic     req,
    output data_t    result
);
    localparam int CNT_W = $clog2(LAT + 1);

    op_e              op_q;
    operand_t         j_q;
    operand_t         k_q;
    logic [CNT_W-1:0] cnt_q;
    logic             both_ready;

    assign both_ready = (j_q.q == '0) && (k_q.q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            op_q  <= OP_ADD;
            j_q   <= '0;
            k_q   <= '0;
            cnt_q <= '0;
        end else if (alloc) begin
            busy  <= 1'b1;
            op_q  <= op_in;
            j_q   <= opj_in;
            k_q   <= opk_in;
            cnt_q <= CNT_W'(LAT);
        end else if (busy) begin
            if (grant) begin
                busy <= 1'b0;
            end else begin
                if (j_q.q != '0 && bus.valid && bus.tag == j_q.q) begin
                    j_q.q <= '0;
                    j_q.v <= bus.data;
                end
                if (k_q.q != '0 && bus.valid && bus.tag == k_q.q) begin
                    k_q.q <= '0;
                    k_q.v <= bus.data;
                end
                if (both_ready && cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign req    = busy && both_ready && (cnt_q == '0);
    assign result = compute(op_q, j_q.v, k_q.v);
endmodule

// File: rtl/rs_regfile.sv
`timescale 1ns/1ps
module rs_regfile
    import rs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ren_en,
    input  reg_t     ren_reg,
    input  tag_t     ren_tag,
    input  bcast_t   bus,
    input  reg_t     src_a,
    input  reg_t     src_b,
    output operand_t opa,
    output operand_t opb,
    input  reg_t     obs_reg,
    output data_t    obs_value,
    output tag_t     obs_tag
);
    data_t value_q [NUM_REGS];
    tag_t  stat_q  [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rst) begin
                value_q[r] <= init_value(r);
                stat_q[r]  <= '0;
            end else begin
                if (bus.valid && stat_q[r] != '0 && stat_q[r] == bus.tag)
                    value_q[r] <= bus.data;
                if (ren_en && ren_reg == reg_t'(r))
                    stat_q[r] <= ren_tag;
                else if (bus.valid && stat_q[r] != '0 && stat_q[r] == bus.tag)
                    stat_q[r] <= '0;
            end
        end
    end

    assign opa       = fetch(stat_q[src_a], value_q[src_a], bus);
    assign opb       = fetch(stat_q[src_b], value_q[src_b], bus);
    assign obs_value = value_q[obs_reg];
    assign obs_tag   = stat_q[obs_reg];
endmodule

// File: rtl/rs_core.sv
`timescale 1ns/1ps
module rs_core
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    output logic              iss_ready,
    output logic              bcast_valid,
    output logic [TAG_W-1:0]  bcast_tag,
    output logic [DATA_W-1:0] bcast_data,
    input  logic [REG_W-1:0]  obs_reg,
    output logic [DATA_W-1:0] obs_value,
    output logic [TAG_W-1:0]  obs_tag
);
    op_e             op;
    logic            want_mul;
    logic            fire;
    logic [N_RS-1:0] busy_vec;
    logic [N_RS-1:0] req_vec;
    logic [N_RS-1:0] grant_vec;
    logic [N_RS-1:0] alloc_vec;
    logic [N_ADD-1:0] add_pick;
    logic [N_MUL-1:0] mul_pick;
    data_t           result [N_RS];
    tag_t            new_tag;
    operand_t        opa;
    operand_t        opb;
    bcast_t          bus;

    assign op       = op_e'(iss_op);
    assign want_mul = uses_mul(op);

    rs_arbiter #(.N(N_ADD)) u_pick_add (.req(~busy_vec[N_ADD-1:0]),    .grant(add_pick));
    rs_arbiter #(.N(N_MUL)) u_pick_mul (.req(~busy_vec[N_RS-1:N_ADD]), .grant(mul_pick));

    assign iss_ready = want_mul ? |mul_pick : |add_pick;
    assign fire      = iss_valid && iss_ready;
    assign alloc_vec = !fire    ? '0 :
                       want_mul ? {mul_pick, {N_ADD{1'b0}}} :
                                  {{N_MUL{1'b0}}, add_pick};

    always_comb begin
        new_tag = '0;
        for (int i = 0; i < N_RS; i++)
            if (alloc_vec[i]) new_tag = tag_t'(i + 1);
    end

    rs_regfile u_regs (
        .clk(clk), .rst(rst),
        .ren_en(fire), .ren_reg(iss_dst), .ren_tag(new_tag),
        .bus(bus),
        .src_a(iss_src1), .src_b(iss_src2), .opa(opa), .opb(opb),
        .obs_reg(obs_reg), .obs_value(obs_value), .obs_tag(obs_tag)
    );

    for (genvar i = 0; i < N_RS; i++) begin : g_rs
        localparam int LAT_I = (i < N_ADD) ? ADD_LAT : MUL_LAT;
        rs_station #(.LAT(LAT_I)) u_rs (
            .clk(clk), .rst(rst),
            .alloc(alloc_vec[i]), .op_in(op), .opj_in(opa), .opk_in(opb),
            .bus(bus), .grant(grant_vec[i]),
            .busy(busy_vec[i]), .req(req_vec[i]), .result(result[i])
        );
    end

    rs_arbiter #(.N(N_RS)) u_bus_arb (.req(req_vec), .grant(grant_vec));

    always_comb begin
        bus = '0;
        for (int i = 0; i < N_RS; i++) begin
            if (grant_vec[i]) begin
                bus.valid = 1'b1;
                bus.tag   = tag_t'(i + 1);
                bus.data  = result[i];
            end
        end
    end

    assign bcast_valid = bus.valid;
    assign bcast_tag   = bus.tag;
    assign bcast_data  = bus.data;
endmodule

// File: rtl/rs_core_chk.sv
`timescale 1ns/1ps
module rs_core_chk
    import rs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            iss_ready,
    input logic [N_RS-1:0] busy_vec,
    input logic [N_RS-1:0] alloc_vec,
    input logic [N_RS-1:0] grant_vec,
    input logic            bcast_valid,
    input logic [TAG_W-1:0] bcast_tag
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !bcast_valid);

    assert_tag_range_R3: assert property (@(posedge clk) disable iff (rst)
        bcast_valid |-> (bcast_tag != '0 && int'(bcast_tag) <= N_RS));

    assert_alloc_free_R4: assert property (@(posedge clk) disable iff (rst)
        ((alloc_vec & busy_vec) == '0) && $onehot0(alloc_vec));

    assert_no_alloc_full_R4: assert property (@(posedge clk) disable iff (rst)
        !iss_ready |-> (alloc_vec == '0));

    assert_grant_single_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    assert_freed_after_bcast_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_vec != '0) |=> ((busy_vec & $past(grant_vec)) == '0));

    assert_no_repeat_tag_R9: assert property (@(posedge clk) disable iff (rst)
        bcast_valid |=> !(bcast_valid && bcast_tag == $past(bcast_tag)));
endmodule

bind rs_core rs_core_chk u_chk (
    .clk(clk), .rst(rst), .iss_ready(iss_ready),
    .busy_vec(busy_vec), .alloc_vec(alloc_vec), .grant_vec(grant_vec),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
);

// File: tb/rs_core_test.sv
`timescale 1ns/1ps
module rs_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = 2'd0;
    logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic        iss_ready;
    logic        bcast_valid;
    logic [3:0]  bcast_tag;
    logic [63:0] bcast_data;
    logic [2:0]  obs_reg = '0;
    logic [63:0] obs_value;
    logic [3:0]  obs_tag;

    rs_core uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .bcast_data(bcast_data), .obs_reg(obs_reg), .obs_value(obs_value),
        .obs_tag(obs_tag)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [3:0]  tag;
        logic [63:0] data;
        int          cyc;
        string       req;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_mis = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_bus(logic [3:0] tag, logic [63:0] data, int c, string req);
        exp_t e;
        e.tag = tag; e.data = data; e.cyc = c; e.req = req;
        expq.push_back(e);
    endtask

    task automatic issue(logic [1:0] op, logic [2:0] d, logic [2:0] s1, logic [2:0] s2,
                         output int ic);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src1 = s1; iss_src2 = s2;
        ic = cyc + 1;
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic obs_chk(string req, logic [2:0] r, logic [63:0] v, logic [3:0] t);
        obs_reg = r;
        #2;
        chk({req, " value"}, obs_value, v);
        chk({req, " tag"}, {60'd0, obs_tag}, {60'd0, t});
    endtask

    // Monitor: each broadcast must match an expected item for its tag.
    always @(negedge clk) begin
        if (!rst && bcast_valid) begin
            int idx = -1;
            for (int i = 0; i < expq.size(); i++)
                if (idx < 0 && expq[i].tag == bcast_tag) idx = i;
            if (idx < 0) begin
                n_cmp++; n_mis++;
                $display("FAIL R2 unexpected broadcast: actual tag %0d data %0d expected none",
                         bcast_tag, bcast_data);
            end else begin
                chk({expq[idx].req, " data"}, bcast_data, expq[idx].data);
                if (expq[idx].cyc >= 0)
                    chk({expq[idx].req, " cycle"}, 64'(cyc), 64'(expq[idx].cyc));
                expq.delete(idx);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        int k, k1, k2, k3;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1 bus idle", {63'd0, bcast_valid}, 64'd0);
        iss_op = 2'd0; #1 chk("R1 adder ready", {63'd0, iss_ready}, 64'd1);
        iss_op = 2'd2; #1 chk("R1 mult ready", {63'd0, iss_ready}, 64'd1);
        for (int r = 0; r < 8; r++) obs_chk("R1 reg", 3'(r), 64'(r + 1), 4'd0);

        // R2/R6: single add, rename visible, then written back
        issue(2'd0, 3'd1, 3'd2, 3'd3, k);
        expect_bus(4'd1, 64'd7, k + 2, "R2 add");
        obs_chk("R6 rename r1", 3'd1, 64'd2, 4'd1);
        idle(6);
        obs_chk("R6 writeback r1", 3'd1, 64'd7, 4'd0);

        // R2: subtract and multiply back to back
        issue(2'd1, 3'd4, 3'd6, 3'd2, k);
        expect_bus(4'd1, 64'd4, k + 2, "R2 sub");
        issue(2'd2, 3'd5, 3'd2, 3'd3, k);
        expect_bus(4'd4, 64'd12, k + 3, "R2 mul");
        idle(6);
        obs_chk("R2 r4", 3'd4, 64'd4, 4'd0);
        obs_chk("R2 r5", 3'd5, 64'd12, 4'd0);

        // R3/R5: dependent chain mul -> add -> add
        issue(2'd2, 3'd6, 3'd2, 3'd3, k);
        expect_bus(4'd4, 64'd12, k + 3, "R3 mul tag");
        issue(2'd0, 3'd7, 3'd6, 3'd1, k1);
        expect_bus(4'd1, 64'd19, k + 6, "R5 dep add");
        issue(2'd0, 3'd0, 3'd7, 3'd7, k2);
        expect_bus(4'd2, 64'd38, k + 9, "R5 dep add chained");
        obs_chk("R3 r6 tag", 3'd6, 64'd7, 4'd4);
        obs_chk("R3 r7 tag", 3'd7, 64'd8, 4'd1);
        obs_chk("R3 r0 tag", 3'd0, 64'd1, 4'd2);
        idle(12);
        obs_chk("R5 r0", 3'd0, 64'd38, 4'd0);
        obs_chk("R5 r7", 3'd7, 64'd19, 4'd0);

        // R7: consumer presented in the producer's broadcast cycle
        issue(2'd0, 3'd1, 3'd3, 3'd5, k);
        expect_bus(4'd1, 64'd16, k + 2, "R7 producer");
        idle(2);
        issue(2'd0, 3'd2, 3'd1, 3'd4, k1);
        chk("R7 issue cycle", 64'(k1), 64'(k + 3));
        expect_bus(4'd2, 64'd20, k + 5, "R7 bypass consumer");
        idle(6);
        obs_chk("R7 r2", 3'd2, 64'd20, 4'd0);

        // R8/R6: simultaneous finish on the same destination
        issue(2'd2, 3'd3, 3'd2, 3'd2, k);
        issue(2'd0, 3'd3, 3'd4, 3'd4, k1);
        expect_bus(4'd1, 64'd8, k + 3, "R8 low tag first");
        expect_bus(4'd4, 64'd400, k + 4, "R8 loser next cycle");
        idle(6);
        obs_chk("R6 newer rename kept r3", 3'd3, 64'd8, 4'd0);

        // R4/R9: fill all adder stations behind a pending multiply
        issue(2'd2, 3'd7, 3'd5, 3'd5, k);
        expect_bus(4'd4, 64'd144, k + 3, "R5 mul producer");
        issue(2'd0, 3'd0, 3'd7, 3'd1, k1);
        issue(2'd0, 3'd1, 3'd7, 3'd1, k2);
        issue(2'd0, 3'd2, 3'd7, 3'd7, k3);
        expect_bus(4'd1, 64'd160, k + 6, "R8 order tag1");
        expect_bus(4'd2, 64'd160, k + 7, "R8 order tag2");
        expect_bus(4'd3, 64'd288, k + 8, "R8 order tag3");
        @(negedge clk);
        iss_op = 2'd2; iss_valid = 1'b0;
        #1 chk("R4 mult still ready", {63'd0, iss_ready}, 64'd1);
        iss_op = 2'd0; iss_dst = 3'd4; iss_src1 = 3'd1; iss_src2 = 3'd1; iss_valid = 1'b1;
        #1 chk("R4 adder full", {63'd0, iss_ready}, 64'd0);
        @(posedge clk);
        #1 iss_valid = 1'b0;
        obs_chk("R4 ignored issue r4", 3'd4, 64'd4, 4'd0);
        idle(10);
        @(negedge clk);
        iss_op = 2'd0;
        #1 chk("R9 adder free again", {63'd0, iss_ready}, 64'd1);
        obs_chk("R9 r0", 3'd0, 64'd160, 4'd0);
        obs_chk("R9 r1", 3'd1, 64'd160, 4'd0);
        obs_chk("R9 r2", 3'd2, 64'd288, 4'd0);
        obs_chk("R9 r7", 3'd7, 64'd144, 4'd0);

        chk("R2 all results seen", 64'(expq.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule